// File: doc/BRIEF.md
# Packet-Addressed Dot-Product Tile with Attestation Receipt

This block is one compute tile on a packet fabric. It accepts 32-bit request packets over a valid/ready input. It acts only on packets that carry its own tile id in the destination field. Load requests fill per-lane A and B operand registers, an 8-bit job id and an 8-bit nonce. The operand registers drive an external combinational dot-product unit. A compute request captures the 16-bit value that unit returns.

A read request makes the tile send two packets, in order, over a valid/ready output. The first is a RESULT packet carrying the captured value. The second is a RECEIPT packet that names the producing tile and the settled operation. It also carries a byte checksum formed by XOR-ing the job id with the low result byte, so a host can tie the work to this tile.

The input is held off while this pair is pending. Packets for other tiles, and packets with unknown op codes, are taken and dropped. A lane-count parameter (4 or 8) sets how many low bits of the lane field pick the operand lane.

Top module: `pkt_compute_tile`

## Requirements
- R1: After reset, pkt_in_ready is 1, pkt_out_valid is 0, and every operand lane and the nonce read 0.
- R2: An accepted packet with op [31:28]=1 writes payload [15:0] into A lane L; op=2 does the same for B lane L. L is the low log2(LANES) bits of the lane field [23:20]. Lane i appears on bits [16i+15:16i] of its operand bus.
- R3: Op 7 stores payload [7:0] as the job id. Op 8 stores payload [7:0] as the nonce, which is shown on the nonce output.
- R4: A packet whose destination field [27:26] differs from TILE_ID is accepted and changes no operand, nonce, job id or result.
- R5: A packet with an op code other than 1, 2, 3, 5, 7 or 8 is accepted and has no effect.
- R6: Op 3 (compute) captures dot_result in the cycle the packet is accepted. Later changes on dot_result do not alter the captured value.
- R7: Op 5 (read) makes pkt_out_valid rise on the next clock with a RESULT packet. That packet holds op 4 in [31:28], 0 in [27:26], TILE_ID in [25:24], 0 in [23:16] and the captured result in [15:0].
- R8: In the cycle after the RESULT handshake, and never earlier, a RECEIPT packet is offered. It holds op 6 in [31:28], 0 in [27:26], TILE_ID in [25:24], 3 in [23:20], 0 in [19:16], job id XOR result[7:0] in [15:8], and the job id in [7:0].
- R9: While pkt_out_valid is 1 and pkt_out_ready is 0, pkt_out_valid and pkt_out_pkt stay unchanged.
- R10: pkt_in_ready is 0 from the cycle after a read is accepted until the RECEIPT handshake completes.
- R11: With LANES=8, lane field values 4 to 7 address operand lanes 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_in_valid | input | 1 | Request packet valid |
| pkt_in_ready | output | 1 | Tile can take a request |
| pkt_in | input | 32 | Request packet |
| pkt_out_valid | output | 1 | Response packet valid |
| pkt_out_ready | input | 1 | Receiver takes the response |
| pkt_out_pkt | output | 32 | Response packet (RESULT or RECEIPT) |
| opnd_a | output | LANES*16 | A operand lanes to the dot-product unit |
| opnd_b | output | LANES*16 | B operand lanes to the dot-product unit |
| nonce | output | 8 | Stored nonce |
| dot_result | input | 16 | Result from the dot-product unit |

## Verification
The embedded assertions check, on every cycle, that a pending response keeps its packet stable under back-pressure. They check that a RECEIPT only ever follows a completed RESULT handshake, with a checksum consistent with the result byte just sent. They also check that the input stays blocked while a response is in flight, and that a packet for another tile leaves the operands and nonce untouched. Field placement, lane addressing in both lane-count variants, the capture point of compute, and the drop of unknown ops can only be shown by the bench's directed scenarios. Those scenarios compare full packets and buses against values built from the requirements.

// File: rtl/pkt_tile_pkg.sv
package pkt_tile_pkg;
  localparam int PKT_W  = 32;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OPC_LOAD_A  = 4'h1;
  localparam logic [3:0] OPC_LOAD_B  = 4'h2;
  localparam logic [3:0] OPC_COMPUTE = 4'h3;
  localparam logic [3:0] OPC_RESULT  = 4'h4;
  localparam logic [3:0] OPC_READ    = 4'h5;
  localparam logic [3:0] OPC_RECEIPT = 4'h6;
  localparam logic [3:0] OPC_JOB     = 4'h7;
  localparam logic [3:0] OPC_NONCE   = 4'h8;

  typedef enum logic [1:0] {
    RSP_IDLE    = 2'd0,
    RSP_RESULT  = 2'd1,
    RSP_RECEIPT = 2'd2
  } rsp_state_e;

  function automatic logic [PKT_W-1:0] build_result(input logic [1:0] tid,
                                                    input logic [WORD_W-1:0] res);
    build_result = {OPC_RESULT, 2'b00, tid, 8'h00, res};
  endfunction

  function automatic logic [PKT_W-1:0] build_receipt(input logic [1:0] tid,
                                                     input logic [BYTE_W-1:0] job,
                                                     input logic [WORD_W-1:0] res);
    build_receipt = {OPC_RECEIPT, 2'b00, tid, OPC_COMPUTE, 4'h0,
                     job ^ res[BYTE_W-1:0], job};
  endfunction
endpackage

// File: rtl/tile_decode.sv
module tile_decode
  import pkt_tile_pkg::*;
#(
  parameter int TILE_ID    = 0,
  parameter int LANE_IDX_W = 2
) (
  input  logic                  take,
  input  logic [PKT_W-1:0]      pkt,
  output logic                  wr_a,
  output logic                  wr_b,
  output logic                  wr_job,
  output logic                  wr_nonce,
  output logic                  do_compute,
  output logic                  do_read,
  output logic [LANE_IDX_W-1:0] lane_idx,
  output logic [WORD_W-1:0]     payload
);
  logic       for_me;
  logic [3:0] opc;
  logic       unused_hdr;

  assign opc        = pkt[31:28];
  assign for_me     = take && (pkt[27:26] == 2'(TILE_ID));
  assign lane_idx   = pkt[20 +: LANE_IDX_W];
  assign payload    = pkt[WORD_W-1:0];
  assign unused_hdr = ^pkt[25:16];

  always_comb begin
    wr_a       = 1'b0;
    wr_b       = 1'b0;
    wr_job     = 1'b0;
    wr_nonce   = 1'b0;
    do_compute = 1'b0;
    do_read    = 1'b0;
    if (for_me) begin
      unique case (opc)
        OPC_LOAD_A:  wr_a       = 1'b1;
        OPC_LOAD_B:  wr_b       = 1'b1;
        OPC_JOB:     wr_job     = 1'b1;
        OPC_NONCE:   wr_nonce   = 1'b1;
        OPC_COMPUTE: do_compute = 1'b1;
        OPC_READ:    do_read    = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tile_lane_bank.sv
module tile_lane_bank
  import pkt_tile_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_a,
  input  logic                    wr_b,
  input  logic [LANE_IDX_W-1:0]   lane_idx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [LANES*WORD_W-1:0] a_bus,
  output logic [LANES*WORD_W-1:0] b_bus
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              hit, en_a, en_b;
    logic [WORD_W-1:0] a_q, b_q;

    assign hit  = (lane_idx == LANE_IDX_W'(i));
    assign en_a = wr_a && hit;
    assign en_b = wr_b && hit;

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        if (en_a) a_q <= wdata;
        if (en_b) b_q <= wdata;
      end
    end

    assign a_bus[i*WORD_W +: WORD_W] = a_q;
    assign b_bus[i*WORD_W +: WORD_W] = b_q;
  end
endmodule

// File: rtl/tile_resp_seq.sv
module tile_resp_seq
  import pkt_tile_pkg::*;
#(
  parameter int TILE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_job,
  input  logic              do_compute,
  input  logic              do_read,
  input  logic [BYTE_W-1:0] job_in,
  input  logic [WORD_W-1:0] dot_result,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [PKT_W-1:0]  out_pkt,
  output logic              idle
);
  rsp_state_e        state_q, state_d;
  logic [BYTE_W-1:0] job_q;
  logic [WORD_W-1:0] res_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RSP_IDLE:    if (do_read)   state_d = RSP_RESULT;
      RSP_RESULT:  if (out_ready) state_d = RSP_RECEIPT;
      RSP_RECEIPT: if (out_ready) state_d = RSP_IDLE;
      default:                    state_d = RSP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RSP_IDLE;
      job_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (wr_job)     job_q <= job_in;
      if (do_compute) res_q <= dot_result;
    end
  end

  assign idle      = (state_q == RSP_IDLE);
  assign out_valid = !idle;

  always_comb begin
    unique case (state_q)
      RSP_RESULT:  out_pkt = build_result(2'(TILE_ID), res_q);
      RSP_RECEIPT: out_pkt = build_receipt(2'(TILE_ID), job_q, res_q);
      default:     out_pkt = '0;
    endcase
  end

  // R9: an offered packet holds while the receiver stalls
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));

  // R8: the receipt appears only after a RESULT handshake or while it waits
  assert_receipt_order_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_pkt[31:28] == OPC_RECEIPT) |->
      ($past(out_valid && out_ready && out_pkt[31:28] == OPC_RESULT) ||
       $past(out_valid && !out_ready && out_pkt[31:28] == OPC_RECEIPT)));

  // R8: RESULT handshake leads directly to a receipt with a matching checksum
  assert_receipt_follows_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_ready && out_pkt[31:28] == OPC_RESULT) |=>
      (out_valid && out_pkt[31:28] == OPC_RECEIPT &&
       (out_pkt[15:8] ^ out_pkt[7:0]) == $past(out_pkt[7:0])));
endmodule

// File: rtl/pkt_compute_tile.sv
module pkt_compute_tile
  import pkt_tile_pkg::*;
#(
  parameter int TILE_ID = 0,
  parameter int LANES   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_in_valid,
  output logic                    pkt_in_ready,
  input  logic [31:0]             pkt_in,
  output logic                    pkt_out_valid,
  input  logic                    pkt_out_ready,
  output logic [31:0]             pkt_out_pkt,
  output logic [LANES*16-1:0]     opnd_a,
  output logic [LANES*16-1:0]     opnd_b,
  output logic [7:0]              nonce,
  input  logic [15:0]             dot_result
);
  localparam int LANE_IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  take, seq_idle;
  logic                  wr_a, wr_b, wr_job, wr_nonce, do_compute, do_read;
  logic [LANE_IDX_W-1:0] lane_idx;
  logic [WORD_W-1:0]     payload;
  logic [BYTE_W-1:0]     nonce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pkt_in_ready = rst_int_n && seq_idle;
  assign take         = pkt_in_valid && pkt_in_ready;

  tile_decode #(.TILE_ID(TILE_ID), .LANE_IDX_W(LANE_IDX_W)) u_dec (
    .take(take), .pkt(pkt_in), .wr_a(wr_a), .wr_b(wr_b), .wr_job(wr_job),
    .wr_nonce(wr_nonce), .do_compute(do_compute), .do_read(do_read),
    .lane_idx(lane_idx), .payload(payload)
  );

  tile_lane_bank #(.LANES(LANES), .LANE_IDX_W(LANE_IDX_W)) u_bank (
    .clk(clk), .rst_ni(rst_int_n), .wr_a(wr_a), .wr_b(wr_b),
    .lane_idx(lane_idx), .wdata(payload), .a_bus(opnd_a), .b_bus(opnd_b)
  );

  tile_resp_seq #(.TILE_ID(TILE_ID)) u_seq (
    .clk(clk), .rst_ni(rst_int_n), .wr_job(wr_job), .do_compute(do_compute),
    .do_read(do_read), .job_in(payload[BYTE_W-1:0]), .dot_result(dot_result),
    .out_ready(pkt_out_ready), .out_valid(pkt_out_valid), .out_pkt(pkt_out_pkt),
    .idle(seq_idle)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    nonce_q <= '0;
    else if (wr_nonce) nonce_q <= payload[BYTE_W-1:0];
  end
  assign nonce = nonce_q;

  // R10: no request is taken while a response is offered
  assert_in_blocked_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    pkt_out_valid |-> !pkt_in_ready);

  // R4: a packet for another tile leaves the stored state alone
  assert_foreign_ignored_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take && pkt_in[27:26] != 2'(TILE_ID)) |=>
      ($stable(opnd_a) && $stable(opnd_b) && $stable(nonce)));

  // R7: a read starts the RESULT packet on the next clock
  assert_read_starts_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take && pkt_in[27:26] == 2'(TILE_ID) && pkt_in[31:28] == OPC_READ) |=>
      (pkt_out_valid && pkt_out_pkt[31:28] == OPC_RESULT));
endmodule

// File: tb/pkt_compute_tile_tb_top.sv
`timescale 1ns/1ps
module pkt_compute_tile_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  in_pkt;
  logic         in_ready, in_ready8;
  logic         out_valid, out_valid8;
  logic         out_ready;
  logic [31:0]  out_pkt, out_pkt8;
  logic [63:0]  opa, opb;
  logic [127:0] opa8, opb8;
  logic [7:0]   nonce, nonce8;
  logic [15:0]  dot_res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [1:0] MY_ID = 2'd1;

  always #2 clk = ~clk;

  pkt_compute_tile #(.TILE_ID(1), .LANES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_in_valid(in_valid), .pkt_in_ready(in_ready),
    .pkt_in(in_pkt), .pkt_out_valid(out_valid), .pkt_out_ready(out_ready),
    .pkt_out_pkt(out_pkt), .opnd_a(opa), .opnd_b(opb), .nonce(nonce),
    .dot_result(dot_res)
  );

  pkt_compute_tile #(.TILE_ID(2), .LANES(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .pkt_in_valid(in_valid), .pkt_in_ready(in_ready8),
    .pkt_in(in_pkt), .pkt_out_valid(out_valid8), .pkt_out_ready(1'b1),
    .pkt_out_pkt(out_pkt8), .opnd_a(opa8), .opnd_b(opb8), .nonce(nonce8),
    .dot_result(16'h0000)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [1:0] dst,
                                     input logic [3:0] lane, input logic [15:0] pl);
    mk = {op, dst, 2'b00, lane, 4'h0, pl};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    in_pkt   = p;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // read with a stall of 2 cycles on the RESULT, then take both packets
  task automatic read_pair(input logic [15:0] exp_res, input logic [7:0] job);
    logic [31:0] first;
    out_ready = 1'b0;
    send(mk(4'h5, MY_ID, 4'h0, 16'h0));
    check("R7 valid after read", {31'b0, out_valid}, 32'd1);
    check("R7 result packet", out_pkt, {4'h4, 2'b00, MY_ID, 8'h00, exp_res});
    check("R10 in_ready low while pending", {31'b0, in_ready}, 32'd0);
    first = out_pkt;
    repeat (2) @(posedge clk);
    #1;
    check("R9 stalled packet held", out_pkt, first);
    check("R9 stalled valid held", {31'b0, out_valid}, 32'd1);
    check("R8 no receipt before handshake", {28'b0, out_pkt[31:28]}, 32'd4);
    @(negedge clk) out_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R8 receipt packet", out_pkt,
          {4'h6, 2'b00, MY_ID, 4'h3, 4'h0, job ^ exp_res[7:0], job});
    check("R10 in_ready low during receipt", {31'b0, in_ready}, 32'd0);
    @(posedge clk);
    #1;
    check("R10 in_ready back after receipt", {31'b0, in_ready}, 32'd1);
    check("R8 pair complete", {31'b0, out_valid}, 32'd0);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 opnd_a low", opa[31:0], 32'd0);
    check("R1 opnd_b high", opb[63:32], 32'd0);
    check("R1 nonce", {24'b0, nonce}, 32'd0);
  endtask

  task automatic t_loads;
    for (int i = 0; i < 4; i++) begin
      send(mk(4'h1, MY_ID, 4'(i), 16'h1000 + 16'(i)));
      send(mk(4'h2, MY_ID, 4'(i), 16'hB000 + 16'(i * 3)));
    end
    for (int i = 0; i < 4; i++) begin
      check("R2 A lane", {16'b0, opa[i*16 +: 16]}, 32'h1000 + 32'(i));
      check("R2 B lane", {16'b0, opb[i*16 +: 16]}, 32'hB000 + 32'(i * 3));
    end
    send(mk(4'h8, MY_ID, 4'h0, 16'hFF3C));
    check("R3 nonce low byte", {24'b0, nonce}, 32'h3C);
  endtask

  task automatic t_ignored;
    send(mk(4'h1, 2'd3, 4'h0, 16'hDEAD));
    send(mk(4'h8, 2'd0, 4'h0, 16'h0077));
    check("R4 foreign A ignored", {16'b0, opa[15:0]}, 32'h1000);
    check("R4 foreign nonce ignored", {24'b0, nonce}, 32'h3C);
    send(mk(4'h9, MY_ID, 4'h1, 16'hCAFE));
    send(mk(4'h4, MY_ID, 4'h2, 16'hCAFE));
    send(mk(4'hF, MY_ID, 4'h3, 16'hCAFE));
    check("R5 unknown op opnd_a", opa, {16'h1003, 16'h1002, 16'h1001, 16'h1000});
    check("R5 unknown op no output", {31'b0, out_valid}, 32'd0);
    check("R5 unknown op consumed", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_compute_read;
    send(mk(4'h7, MY_ID, 4'h0, 16'hAB5A));
    dot_res = 16'h47C0;
    send(mk(4'h3, MY_ID, 4'h0, 16'h0));
    dot_res = 16'h1234;
    send(mk(4'h3, 2'd0, 4'h0, 16'h0));
    send(mk(4'h7, 2'd3, 4'h0, 16'h0011));
    read_pair(16'h47C0, 8'h5A); // R6 capture, R4 foreign compute/job, R3 job
  endtask

  task automatic t_second_read;
    send(mk(4'h7, MY_ID, 4'h0, 16'h00FF));
    dot_res = 16'h8001;
    send(mk(4'h3, MY_ID, 4'h0, 16'h0));
    dot_res = 16'h0000;
    read_pair(16'h8001, 8'hFF); // R8 checksum with new job
  endtask

  task automatic t_wide;
    send(mk(4'h1, 2'd2, 4'h6, 16'hBEEF));
    send(mk(4'h2, 2'd2, 4'h4, 16'h0101));
    send(mk(4'h1, 2'd2, 4'h7, 16'h7777));
    check("R11 A lane 6", {16'b0, opa8[6*16 +: 16]}, 32'hBEEF);
    check("R11 A lane 7", {16'b0, opa8[7*16 +: 16]}, 32'h7777);
    check("R11 B lane 4", {16'b0, opb8[4*16 +: 16]}, 32'h0101);
    check("R11 A lane 2 untouched", {16'b0, opa8[2*16 +: 16]}, 32'h0);
    check("R11 other tile untouched", opa, {16'h1003, 16'h1002, 16'h1001, 16'h1000});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_pkt    = '0;
    out_ready = 1'b0;
    dot_res   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_loads();
    t_ignored();
    t_compute_read();
    t_second_read();
    t_wide();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule